// File: doc/BRIEF.md
# Maximum Bit-Count Scan Engine

This peripheral searches a block of memory for the word with the most set bits, without help from the processor. Software writes a start address into a configuration register and then sets a start bit. From then on the engine works as a bus master. It fetches 1024 consecutive 32-bit words, counts the ones in each word and keeps two results: the highest count seen so far and the position of the first word that reached that count. When the last word has been processed, the engine raises a done flag. If interrupts are enabled, the flag also drives an interrupt line. Software can poll the flag or wait for the interrupt, and then read both results back.

The scan is run by a four-state machine.
- **IDLE**: the engine waits. A start request moves it to READ_REQ, and at that moment the start address is latched and the word index is reset to zero.
- **READ_REQ**: the engine presents a read request. It stays here until the memory accepts the request, then moves to WAIT_RESP.
- **WAIT_RESP**: the engine waits for the response data. When it arrives, the word's bit count is compared with the running best. The machine then returns to READ_REQ for the next word, or moves to DONE if the word was the last one.
- **DONE**: this state lasts one cycle. It sets the sticky done flag and returns to IDLE.

Software reaches the engine through a small word-indexed register port, selected by `reg_addr`:

| Offset | Register | Contents |
|---|---|---|
| 0 | Start address | Byte address of the first word |
| 1 | Control | Bit 0 = start (write only, reads 0); bit 1 = interrupt enable |
| 2 | Status | Bit 0 = busy; bit 1 = done (write 1 to clear) |
| 3 | Best count | Highest bit count found |
| 4 | Best index | Position of the first word with that count |

Reading any other offset returns 0.

Top module: `bitmax_scan_engine`

## Requirements
- R1: After reset, the following are all zero: every readable register, the status bits and `irq`. `mem_req_valid` is low.
- R2: Writing 1 to control bit 0 while the engine is idle starts a scan, and status bit 0 (busy) reads 1 until the scan ends. Writing 1 to control bit 0 while the engine is busy has no effect: it neither restarts the scan nor changes its addresses.
- R3: Word i of a scan (i = 0 to 1023) is requested at byte address start + 4*i, in increasing order of i. The start address is the one latched when the scan started. Each request holds its address stable until `mem_req_ready` accepts it.
- R4: The engine keeps at most one read outstanding. It issues no new request until the response to the previous one has arrived.
- R5: Word 0 always loads the best count and the best index. A later word replaces them only if its bit count is strictly greater. When counts are tied, the lowest index is kept.
- R6: The cycle after the 1024th response, done (status bit 1) is set and busy is cleared. Done stays set until software writes 1 to status bit 1. Writing 0 to that bit leaves done unchanged.
- R7: `irq` is high exactly when done is set and interrupt enable (control bit 1) is 1. Enabling interrupts after the scan has finished raises `irq` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| mem_req_valid | output | 1 | Read request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_addr | output | 32 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data valid for one cycle |
| mem_rsp_data | input | 32 | Read data |
| irq | output | 1 | Level interrupt, done AND interrupt enable |

## Verification
The properties rely on the memory side behaving correctly in two ways. First, `mem_rsp_valid` pulses only once for each accepted request, and only after that request's handshake cycle. Second, while a read is outstanding, the memory never gives a response for some other request. The bench's memory model meets both conditions by construction:
- It records a request only on a cycle where valid and ready are both high.
- It keeps ready low while its single pending response is waiting.
- It releases that response after a random delay of zero to three cycles.

Register writes are issued one at a time, and the register port is always quiet in the cycle around the point where done is cleared.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [1:0] {
        S_IDLE      = 2'd0,
        S_READ_REQ  = 2'd1,
        S_WAIT_RESP = 2'd2,
        S_DONE      = 2'd3
    } scan_state_e;

    localparam int unsigned REG_AW = 3;

    localparam logic [REG_AW-1:0] RA_START_ADDR = 3'd0;
    localparam logic [REG_AW-1:0] RA_CONTROL    = 3'd1;
    localparam logic [REG_AW-1:0] RA_STATUS     = 3'd2;
    localparam logic [REG_AW-1:0] RA_BEST_COUNT = 3'd3;
    localparam logic [REG_AW-1:0] RA_BEST_INDEX = 3'd4;

endpackage

// File: rtl/bit_tally.sv
module bit_tally #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] word_in,
    output logic [CNT_W-1:0]  ones
);

    always_comb begin
        ones = '0;
        for (int b = 0; b < DATA_W; b++) begin
            ones = ones + CNT_W'(word_in[b]);
        end
    end

endmodule

// File: rtl/scan_regs.sv
module scan_regs
    import scan_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 6,
    parameter int unsigned IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              done_set,
    input  logic [CNT_W-1:0]  best_count,
    input  logic [IDX_W-1:0]  best_index,
    output logic [ADDR_W-1:0] start_addr,
    output logic              irq_en,
    output logic              done_flag,
    output logic              start_req,
    output logic              irq
);

    logic wr_start_addr, wr_control, wr_status;

    always_comb begin
        wr_start_addr = reg_we && (reg_addr == RA_START_ADDR);
        wr_control    = reg_we && (reg_addr == RA_CONTROL);
        wr_status     = reg_we && (reg_addr == RA_STATUS);
        start_req     = wr_control && reg_wdata[0] && !busy;
        irq           = done_flag && irq_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_addr <= '0;
            irq_en     <= 1'b0;
            done_flag  <= 1'b0;
        end else begin
            if (wr_start_addr) start_addr <= reg_wdata[ADDR_W-1:0];
            if (wr_control)    irq_en     <= reg_wdata[1];
            if (done_set)
                done_flag <= 1'b1;
            else if (wr_status && reg_wdata[1])
                done_flag <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_START_ADDR: reg_rdata = DATA_W'(start_addr);
            RA_CONTROL:    reg_rdata = DATA_W'({irq_en, 1'b0});
            RA_STATUS:     reg_rdata = DATA_W'({done_flag, busy});
            RA_BEST_COUNT: reg_rdata = DATA_W'(best_count);
            RA_BEST_INDEX: reg_rdata = DATA_W'(best_index);
            default:       reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
    import scan_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned CNT_W      = 6,
    parameter int unsigned WORD_COUNT = 1024,
    parameter int unsigned IDX_W      = $clog2(WORD_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [CNT_W-1:0]  word_ones,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              busy,
    output logic              done_set,
    output logic [CNT_W-1:0]  best_count,
    output logic [IDX_W-1:0]  best_index
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_COUNT - 1);

    scan_state_e       state_q, state_nx;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] scan_base_q;
    logic              last_word;
    logic              take_rsp;

    assign last_word = (idx_q == LAST_IDX);
    assign take_rsp  = (state_q == S_WAIT_RESP) && mem_rsp_valid;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_IDLE:      if (start_req)     state_nx = S_READ_REQ;
            S_READ_REQ:  if (mem_req_ready) state_nx = S_WAIT_RESP;
            S_WAIT_RESP: if (mem_rsp_valid) state_nx = last_word ? S_DONE : S_READ_REQ;
            S_DONE:                         state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q       <= '0;
            scan_base_q <= '0;
            best_count  <= '0;
            best_index  <= '0;
        end else begin
            if ((state_q == S_IDLE) && start_req) begin
                idx_q       <= '0;
                scan_base_q <= start_addr;
            end
            if (take_rsp) begin
                if ((idx_q == '0) || (word_ones > best_count)) begin
                    best_count <= word_ones;
                    best_index <= idx_q;
                end
                if (!last_word) idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        mem_req_valid = (state_q == S_READ_REQ);
        mem_req_addr  = scan_base_q + ADDR_W'({idx_q, 2'b00});
        busy          = (state_q != S_IDLE);
        done_set      = (state_q == S_DONE);
    end

endmodule

// File: rtl/bitmax_scan_engine.sv
module bitmax_scan_engine
    import scan_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned WORD_COUNT = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              irq
);

    localparam int unsigned CNT_W = $clog2(DATA_W + 1);
    localparam int unsigned IDX_W = $clog2(WORD_COUNT);

    logic              busy, done_set, done_flag, start_req, irq_en;
    logic [ADDR_W-1:0] start_addr;
    logic [CNT_W-1:0]  word_ones, best_count;
    logic [IDX_W-1:0]  best_index;

    bit_tally #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_tally (
        .word_in (mem_rsp_data),
        .ones    (word_ones)
    );

    scan_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .done_set   (done_set),
        .best_count (best_count),
        .best_index (best_index),
        .start_addr (start_addr),
        .irq_en     (irq_en),
        .done_flag  (done_flag),
        .start_req  (start_req),
        .irq        (irq)
    );

    scan_fsm #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_COUNT(WORD_COUNT), .IDX_W(IDX_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_req     (start_req),
        .start_addr    (start_addr),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .word_ones     (word_ones),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .busy          (busy),
        .done_set      (done_set),
        .best_count    (best_count),
        .best_index    (best_index)
    );

endmodule

// File: rtl/bitmax_scan_engine_checker.sv
module bitmax_scan_engine_checker #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned CNT_W      = 6,
    parameter int unsigned WORD_COUNT = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [2:0]        reg_addr,
    input logic              wr_bit0,
    input logic              wr_bit1,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              busy,
    input logic              done_flag,
    input logic [ADDR_W-1:0] start_addr,
    input logic [CNT_W-1:0]  best_count
);

    localparam int unsigned CW = $clog2(WORD_COUNT) + 1;

    logic              launch, clear_wr;
    logic [CW-1:0]     req_seen, rsp_seen;
    logic [ADDR_W-1:0] base_seen;
    logic              outstanding;

    assign launch   = reg_we && (reg_addr == 3'd1) && wr_bit0 && !busy;
    assign clear_wr = reg_we && (reg_addr == 3'd2) && wr_bit1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_seen    <= '0;
            rsp_seen    <= '0;
            base_seen   <= '0;
            outstanding <= 1'b0;
        end else begin
            if (launch) begin
                req_seen  <= '0;
                rsp_seen  <= '0;
                base_seen <= start_addr;
            end else begin
                if (mem_req_valid && mem_req_ready) req_seen <= req_seen + 1'b1;
                if (mem_rsp_valid && busy)          rsp_seen <= rsp_seen + 1'b1;
            end
            if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
            else if (mem_rsp_valid)             outstanding <= 1'b0;
        end
    end

    // R3: request address follows the latched start address, word by word
    assert_addr_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr == base_seen + ADDR_W'({req_seen, 2'b00})));

    // R3: an unaccepted request stays put
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R4: nothing new while a read is in flight
    assert_single_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !mem_req_valid);

    // R5: best count never shrinks after word 0
    assert_best_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (rsp_seen > CW'(1))) |-> (best_count >= $past(best_count)));

    // R6: done appears only after every word came back
    assert_done_after_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> (rsp_seen == CW'(WORD_COUNT)));

    // R6: done is sticky until cleared
    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !clear_wr) |=> done_flag);

    // R2: busy falls only together with done being set
    assert_busy_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_flag);

endmodule

bind bitmax_scan_engine bitmax_scan_engine_checker #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_COUNT(WORD_COUNT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .wr_bit0       (reg_wdata[0]),
    .wr_bit1       (reg_wdata[1]),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .busy          (busy),
    .done_flag     (done_flag),
    .start_addr    (start_addr),
    .best_count    (best_count)
);

// File: tb/bitmax_scan_engine_test.sv
module bitmax_scan_engine_test;

    localparam int NW = 1024;

    typedef struct packed {
        logic [3:0]  kind;
        logic [31:0] base;
        logic        use_exp;
        logic [7:0]  exp_max;
        logic [15:0] exp_idx;
        logic        irq_on;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 32'h0000_1000, 1'b1, 8'd0,  16'd0,    1'b1},
        '{4'd1, 32'h8000_0000, 1'b1, 8'd32, 16'd0,    1'b0},
        '{4'd2, 32'h0004_0000, 1'b1, 8'd32, 16'd700,  1'b1},
        '{4'd3, 32'hFFFF_F000, 1'b1, 8'd16, 16'd5,    1'b1},
        '{4'd4, 32'h0000_0000, 1'b1, 8'd32, 16'd32,   1'b0},
        '{4'd5, 32'h1234_5670, 1'b0, 8'd0,  16'd0,    1'b1},
        '{4'd6, 32'h0010_0004, 1'b1, 8'd2,  16'd1023, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        mem_req_valid, mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        irq;

    always #10 clk = ~clk;

    bitmax_scan_engine uut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    logic [31:0] mem_words [NW];
    logic [31:0] cur_base;
    int req_cnt, addr_err, multi_err;
    bit pending;
    int lat;
    logic [31:0] pend_data;
    int ref_max, ref_idx;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pattern(input int kind, input int i);
        int k;
        case (kind)
            0: return 32'h0;
            1: return 32'hFFFF_FFFF;
            2: return (i == 700) ? 32'hFFFF_FFFF : 32'h1;
            3: return (i == 5 || i == 900) ? 32'h00FF_00FF : 32'h0000_000F;
            4: begin k = i % 33; return (k == 0) ? 32'h0 : (32'hFFFF_FFFF >> (32 - k)); end
            5: return $urandom;
            default: return (i == NW - 1) ? 32'h8000_0001 : 32'h1;
        endcase
    endfunction

    task automatic fill_and_model(input int kind);
        for (int i = 0; i < NW; i++) mem_words[i] = pattern(kind, i);
        ref_max = 0; ref_idx = 0;
        for (int i = 0; i < NW; i++) begin
            if (i == 0 || $countones(mem_words[i]) > ref_max) begin
                ref_max = $countones(mem_words[i]);
                ref_idx = i;
            end
        end
    endtask

    // memory model: random accept, one pending response, random latency
    initial begin
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        pending = 1'b0; lat = 0; pend_data = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pending && mem_req_valid) multi_err++;
            if (pending) begin
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pend_data;
                    pending       = 1'b0;
                end else lat--;
            end
            mem_req_ready = !pending && (($urandom % 4) != 0);
            if (mem_req_valid && mem_req_ready) begin
                logic [31:0] w;
                if (mem_req_addr != cur_base + 32'(req_cnt * 4)) addr_err++;
                w = (mem_req_addr - cur_base) >> 2;
                pend_data = (w < NW) ? mem_words[w[9:0]] : 32'h0;
                req_cnt++;
                pending = 1'b1;
                lat = $urandom % 4;
            end
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic start_scan(input logic [31:0] base, input bit irq_on);
        logic [31:0] st;
        cur_base = base; req_cnt = 0; addr_err = 0; multi_err = 0;
        reg_write(3'd0, base);
        reg_write(3'd1, {30'd0, irq_on, 1'b1});
        reg_read(3'd2, st);
        check(st[0] == 1'b1, "R2 busy after start", st[0], 1);
    endtask

    task automatic wait_done();
        logic [31:0] st;
        st = '0;
        while (!st[1]) reg_read(3'd2, st);
        check(st[0] == 1'b0, "R6 busy clear at done", st[0], 0);
    endtask

    task automatic check_results(input bit irq_on);
        logic [31:0] d;
        reg_read(3'd3, d);
        check(d == 32'(ref_max), "R5 best count", d, ref_max);
        reg_read(3'd4, d);
        check(d == 32'(ref_idx), "R5 best index", d, ref_idx);
        check(req_cnt == NW, "R3 request count", req_cnt, NW);
        check(addr_err == 0, "R3 address order", addr_err, 0);
        check(multi_err == 0, "R4 single outstanding", multi_err, 0);
        check(irq == irq_on, "R7 irq at done", irq, irq_on);
    endtask

    task automatic clear_done();
        logic [31:0] st;
        reg_write(3'd2, 32'h2);
        reg_read(3'd2, st);
        check(st[1] == 1'b0, "R6 done cleared", st[1], 0);
        check(irq == 1'b0, "R7 irq low after clear", irq, 0);
    endtask

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        cur_base = '0; req_cnt = 0; addr_err = 0; multi_err = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            reg_read(3'(a), d);
            check(d == 32'h0, "R1 register reset", d, 0);
        end
        check(irq == 1'b0, "R1 irq reset", irq, 0);
        check(mem_req_valid == 1'b0, "R1 no request at reset", mem_req_valid, 0);

        // table-driven scans
        for (int v = 0; v < NV; v++) begin
            fill_and_model(int'(VECS[v].kind));
            if (VECS[v].use_exp) begin
                check(ref_max == int'(VECS[v].exp_max) && ref_idx == int'(VECS[v].exp_idx),
                      "R5 table expectation", ref_max, VECS[v].exp_max);
            end
            start_scan(VECS[v].base, VECS[v].irq_on);
            wait_done();
            check_results(VECS[v].irq_on);
            clear_done();
        end

        // R6/R7: done sticky, write 0 no effect, late interrupt enable
        fill_and_model(4);
        start_scan(32'h0000_2000, 1'b0);
        wait_done();
        check_results(1'b0);
        repeat (30) @(negedge clk);
        reg_read(3'd2, d);
        check(d[1] == 1'b1, "R6 done held", d[1], 1);
        reg_write(3'd2, 32'h0);
        reg_read(3'd2, d);
        check(d[1] == 1'b1, "R6 write 0 keeps done", d[1], 1);
        reg_write(3'd1, 32'h2);
        #1;
        check(irq == 1'b1, "R7 irq on late enable", irq, 1);
        reg_read(3'd2, d);
        check(d[0] == 1'b0, "R2 enable-only write does not start", d[0], 0);
        clear_done();

        // R2: start while busy is ignored
        fill_and_model(5);
        start_scan(32'h0003_0000, 1'b1);
        repeat (200) @(negedge clk);
        reg_write(3'd0, 32'h0777_0000);
        reg_write(3'd1, 32'h3);
        reg_read(3'd2, d);
        check(d[0] == 1'b1, "R2 still busy after second start", d[0], 1);
        wait_done();
        check_results(1'b1);
        repeat (50) @(negedge clk);
        check(req_cnt == NW, "R2 no restart after ignored start", req_cnt, NW);
        reg_read(3'd2, d);
        check(d[0] == 1'b0, "R2 idle after scan", d[0], 0);
        clear_done();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule